// File: doc/BRIEF.md
# Wiper Position Register With One-Hot Tap Select

This block holds the position of one potentiometer wiper as an 8-bit value. It drives a 256-bit select vector in which exactly one bit is set, so that exactly one tap switch of the resistor chain is on. A position of 00h selects the tap at the low end of the chain, and FFh selects the tap at the high end.

The host can change the position in three ways. It can write a value directly. It can copy one of the channel's four stored data values into the register. It can step the wiper up or down by one tap. Leaving reset loads the position from stored value 0, so the register never keeps the value it had before reset. The position value can be read back, and the tap select follows it one clock later.

Top module: `wiper_tap_reg`

## Requirements
- R1: `tap_sel_o` always has exactly one bit set. Bit k of `tap_sel_o` is set when the position it reflects equals k, so 00h drives bit 0 and FFh drives bit 255.
- R2: While `rst_n` is low, `pos_o` is 00h and `tap_sel_o` has only bit 0 set. Reset is released through a two-stage synchronizer. On the third rising clock edge after `rst_n` rises, `pos_o` takes stored value 0, which is `dr_bank_i[7:0]`.
- R3: When `wr_req_i` is high at a clock edge, `pos_o` takes `wr_data_i` at that edge, unless a request of higher precedence is present.
- R4: When `xfer_req_i` is high at a clock edge, `pos_o` takes stored value k, where k is `xfer_sel_i`. Stored value k sits at bits 8k+7 down to 8k of `dr_bank_i`.
- R5: When `step_req_i` is high and no other request is present, `pos_o` rises by one if `step_up_i` is 1 and falls by one if `step_up_i` is 0.
- R6: A step up at FFh leaves the position at FFh, and a step down at 00h leaves it at 00h. Neither wraps around.
- R7: When requests coincide, the order of precedence is the post-reset load first, then the stored-value copy, then the host write, then the step.
- R8: `tap_sel_o` is registered. It changes on the clock edge after the one at which `pos_o` changes.
- R9: With no request present, `pos_o` and `tap_sel_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_bank_i | input | 32 | Four stored 8-bit values; value k at bits 8k+7:8k |
| xfer_req_i | input | 1 | Copy a stored value into the position |
| xfer_sel_i | input | 2 | Index of the stored value to copy |
| wr_req_i | input | 1 | Host write of the position |
| wr_data_i | input | 8 | Host write value |
| step_req_i | input | 1 | Move the position by one tap |
| step_up_i | input | 1 | Step direction: 1 toward FFh, 0 toward 00h |
| pos_o | output | 8 | Current position |
| tap_sel_o | output | 256 | One-hot tap switch enables |

## Verification
A wrong source choice or a wrong step result in the position register shows on `pos_o` at the next falling edge after the request. A fault in the decoder or in its pipeline stage shows one cycle later, as a wrong bit or a wrong count of set bits in `tap_sel_o`. Missing saturation shows at once as a wrap to the opposite end of the range. A missed post-reset load shows as 00h in place of stored value 0, three edges after reset is released.

// File: rtl/wtap_pkg.sv
package wtap_pkg;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_STEP  = 3'd1,
    SRC_WRITE = 3'd2,
    SRC_XFER  = 3'd3,
    SRC_INIT  = 3'd4
  } wtap_src_e;

endpackage

// File: rtl/wtap_rst_sync.sv
module wtap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wtap_pos_ctrl.sv
module wtap_pos_ctrl
  import wtap_pkg::*;
#(
  parameter int W    = 8,
  parameter int NDR  = 4,
  localparam int SELW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [NDR*W-1:0]  dr_bank_i,
  input  logic              xfer_req_i,
  input  logic [SELW-1:0]   xfer_sel_i,
  input  logic              wr_req_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              step_req_i,
  input  logic              step_up_i,
  output logic [W-1:0]      pos_o
);

  localparam logic [W-1:0] POS_MAX = '1;
  localparam logic [W-1:0] POS_MIN = '0;

  logic [W-1:0] dr_arr [NDR];

  genvar gi;
  generate
    for (gi = 0; gi < NDR; gi++) begin : g_dr
      assign dr_arr[gi] = dr_bank_i[gi*W +: W];
    end
  endgenerate

  logic         init_q;
  logic [W-1:0] pos_q;
  wtap_src_e    src;
  logic [W-1:0] pos_nxt;
  logic [W-1:0] step_val;
  logic         pos_en;

  // source selection in fixed precedence
  always_comb begin
    if (init_q)          src = SRC_INIT;
    else if (xfer_req_i) src = SRC_XFER;
    else if (wr_req_i)   src = SRC_WRITE;
    else if (step_req_i) src = SRC_STEP;
    else                 src = SRC_NONE;
  end

  always_comb begin
    if (step_up_i) step_val = (pos_q == POS_MAX) ? pos_q : pos_q + W'(1);
    else           step_val = (pos_q == POS_MIN) ? pos_q : pos_q - W'(1);
  end

  always_comb begin
    pos_en  = 1'b1;
    pos_nxt = pos_q;
    unique case (src)
      SRC_INIT:  pos_nxt = dr_arr[0];
      SRC_XFER:  pos_nxt = dr_arr[xfer_sel_i];
      SRC_WRITE: pos_nxt = wr_data_i;
      SRC_STEP:  pos_nxt = step_val;
      default:   pos_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     pos_q <= '0;
    else if (pos_en) pos_q <= pos_nxt;
  end

  assign pos_o = pos_q;

  // R2: first cycle out of reset loads stored value 0
  a_r2_init_load: assert property (@(posedge clk) disable iff (!srst_n)
    init_q |=> pos_q == $past(dr_bank_i[W-1:0]));

  // R4 / R7: copy wins over write and step
  a_r4_xfer_load: assert property (@(posedge clk) disable iff (!srst_n)
    (xfer_req_i && !init_q) |=> pos_q == $past(dr_bank_i[xfer_sel_i*W +: W]));

  // R3 / R7: write wins over step
  a_r3_write_load: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_req_i && !xfer_req_i && !init_q) |=> pos_q == $past(wr_data_i));

  // R6: no wrap at either end
  a_r6_sat_high: assert property (@(posedge clk) disable iff (!srst_n)
    (step_req_i && step_up_i && pos_q == POS_MAX && !wr_req_i && !xfer_req_i && !init_q)
    |=> pos_q == POS_MAX);

  a_r6_sat_low: assert property (@(posedge clk) disable iff (!srst_n)
    (step_req_i && !step_up_i && pos_q == POS_MIN && !wr_req_i && !xfer_req_i && !init_q)
    |=> pos_q == POS_MIN);

  // R9: idle holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !(init_q || xfer_req_i || wr_req_i || step_req_i) |=> $stable(pos_q));

endmodule

// File: rtl/wtap_decode.sv
module wtap_decode #(
  parameter int W = 8,
  localparam int TAPS = 1 << W
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic [W-1:0]    pos_i,
  output logic [TAPS-1:0] tap_o
);

  localparam logic [TAPS-1:0] TAP_RST = TAPS'(1);

  logic [TAPS-1:0] tap_nxt;
  logic [TAPS-1:0] tap_q;

  genvar gi;
  generate
    for (gi = 0; gi < TAPS; gi++) begin : g_tap
      assign tap_nxt[gi] = (pos_i == W'(gi));
    end
  endgenerate

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) tap_q <= TAP_RST;
    else         tap_q <= tap_nxt;
  end

  assign tap_o = tap_q;

  // R1: never zero or several switches on
  a_r1_one_tap: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(tap_q) == 1);

endmodule

// File: rtl/wiper_tap_reg.sv
module wiper_tap_reg #(
  parameter int W   = 8,
  parameter int NDR = 4,
  localparam int SELW = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int TAPS = 1 << W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDR*W-1:0]  dr_bank_i,
  input  logic              xfer_req_i,
  input  logic [SELW-1:0]   xfer_sel_i,
  input  logic              wr_req_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              step_req_i,
  input  logic              step_up_i,
  output logic [W-1:0]      pos_o,
  output logic [TAPS-1:0]   tap_sel_o
);

  logic srst_n;

  wtap_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  wtap_pos_ctrl #(.W(W), .NDR(NDR)) u_ctrl (
    .clk        (clk),
    .srst_n     (srst_n),
    .dr_bank_i  (dr_bank_i),
    .xfer_req_i (xfer_req_i),
    .xfer_sel_i (xfer_sel_i),
    .wr_req_i   (wr_req_i),
    .wr_data_i  (wr_data_i),
    .step_req_i (step_req_i),
    .step_up_i  (step_up_i),
    .pos_o      (pos_o)
  );

  wtap_decode #(.W(W)) u_dec (
    .clk    (clk),
    .srst_n (srst_n),
    .pos_i  (pos_o),
    .tap_o  (tap_sel_o)
  );

  // R8: tap select reflects the position of the previous cycle
  a_r8_tap_lag: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) || (tap_sel_o == (TAPS'(1) << $past(pos_o))));

endmodule

// File: tb/tb_wiper_tap_reg.sv
module tb_wiper_tap_reg;

  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int NDR   = 4;
  localparam int TAPS  = 1 << W;

  logic              clk;
  logic              rst_n;
  logic [NDR*W-1:0]  dr_bank_i;
  logic              xfer_req_i;
  logic [1:0]        xfer_sel_i;
  logic              wr_req_i;
  logic [W-1:0]      wr_data_i;
  logic              step_req_i;
  logic              step_up_i;
  logic [W-1:0]      pos_o;
  logic [TAPS-1:0]   tap_sel_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  wiper_tap_reg #(.W(W), .NDR(NDR)) dut (
    .clk(clk), .rst_n(rst_n), .dr_bank_i(dr_bank_i),
    .xfer_req_i(xfer_req_i), .xfer_sel_i(xfer_sel_i),
    .wr_req_i(wr_req_i), .wr_data_i(wr_data_i),
    .step_req_i(step_req_i), .step_up_i(step_up_i),
    .pos_o(pos_o), .tap_sel_o(tap_sel_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check_pos(input string req, input logic [W-1:0] exp);
    checks++;
    if (pos_o !== exp) begin
      errors++;
      $display("FAIL %s pos actual %02h expected %02h", req, pos_o, exp);
    end
  endtask

  task automatic check_tap(input string req, input int idx);
    checks++;
    if ($countones(tap_sel_o) != 1 || tap_sel_o[idx] !== 1'b1) begin
      errors++;
      $display("FAIL %s tap actual ones=%0d bit%0d=%b expected only bit %0d",
               req, $countones(tap_sel_o), idx, tap_sel_o[idx], idx);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    xfer_req_i = 0; wr_req_i = 0; step_req_i = 0;
  endtask

  // R2, R7: reset state, post-reset load beats coincident requests
  task automatic t_reset();
    rst_n = 0;
    idle_inputs();
    dr_bank_i = {8'h4D, 8'hC3, 8'h19, 8'hA6};
    #(CLK_P*3);
    @(negedge clk);
    check_pos("R2 in reset", 8'h00);
    check_tap("R2 in reset", 0);
    rst_n = 1;
    cyc();
    cyc();
    xfer_req_i = 1; xfer_sel_i = 2; wr_req_i = 1; wr_data_i = 8'h11;
    step_req_i = 1; step_up_i = 1;
    cyc();
    idle_inputs();
    check_pos("R2 R7 init load", 8'hA6);
    cyc();
    check_tap("R2 R8 tap after init", 8'hA6);
  endtask

  // R3, R8, R1
  task automatic t_write(input logic [W-1:0] v);
    logic [W-1:0] prev;
    prev = pos_o;
    wr_req_i = 1; wr_data_i = v;
    cyc();
    idle_inputs();
    check_pos("R3 host write", v);
    check_tap("R8 tap lags", int'(prev));
    cyc();
    check_tap("R1 tap decode", int'(v));
  endtask

  // R4
  task automatic t_xfer(input int k);
    logic [W-1:0] exp;
    exp = dr_bank_i[k*W +: W];
    xfer_req_i = 1; xfer_sel_i = 2'(k);
    cyc();
    idle_inputs();
    check_pos("R4 copy stored value", exp);
    cyc();
    check_tap("R4 R1 tap after copy", int'(exp));
  endtask

  // R5, R6
  task automatic t_step(input bit up, input logic [W-1:0] exp, input string req);
    step_req_i = 1; step_up_i = up;
    cyc();
    idle_inputs();
    check_pos(req, exp);
    cyc();
    check_tap(req, int'(exp));
  endtask

  // R7: copy over write over step
  task automatic t_priority();
    xfer_req_i = 1; xfer_sel_i = 1; wr_req_i = 1; wr_data_i = 8'h77;
    step_req_i = 1; step_up_i = 0;
    cyc();
    idle_inputs();
    check_pos("R7 copy wins", 8'h19);
    wr_req_i = 1; wr_data_i = 8'h77; step_req_i = 1; step_up_i = 1;
    cyc();
    idle_inputs();
    check_pos("R7 write beats step", 8'h77);
  endtask

  // R9
  task automatic t_hold();
    logic [W-1:0] v;
    v = pos_o;
    wr_data_i = ~v; step_up_i = 1;
    for (int i = 0; i < 4; i++) cyc();
    check_pos("R9 idle hold", v);
    check_tap("R9 idle hold tap", int'(v));
  endtask

  initial begin
    xfer_sel_i = 0; wr_data_i = 0; step_up_i = 0;
    t_reset();
    t_write(8'h3C);
    t_write(8'h00);
    t_write(8'hFF);
    t_xfer(0);
    t_xfer(1);
    t_xfer(2);
    t_xfer(3);
    t_write(8'h80);
    t_step(1, 8'h81, "R5 step up");
    t_step(0, 8'h80, "R5 step down");
    t_step(0, 8'h7F, "R5 step down again");
    t_write(8'hFE);
    t_step(1, 8'hFF, "R5 step up to top");
    t_step(1, 8'hFF, "R6 saturate high");
    t_write(8'h01);
    t_step(0, 8'h00, "R5 step down to bottom");
    t_step(0, 8'h00, "R6 saturate low");
    t_priority();
    t_hold();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P*20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule